// File: doc/BRIEF.md
# Processor Interrupt and Reset Front-End

This block sits between the raw asynchronous control pins of a small CPU core and the core's sequencer. It brings the maskable interrupt request, the non-maskable interrupt, the reset pin and the test pin into the core clock domain through multi-flop synchronizers. At every instruction boundary, marked by a strobe from the core, it decides whether an interrupt is to be taken and produces the type code that the core uses to index its vector table.

The maskable request is a level. It is looked at only in the cycle that closes an instruction, and only while the core's interrupt-enable flag is set. The non-maskable pin is edge sensitive: a rising edge leaves a pending request that waits for the next boundary, ignores the enable flag and wins over the maskable request. A raised request stays on until the core accepts it with a one-cycle handshake. The reset pin must stay high for a minimum number of synchronized cycles after having been seen low before the core reset output rises. Once risen, the output holds until the pin drops, and it flushes every pending request. The synchronized test level is passed on for a wait-for-test instruction.

Top module: `cpu_irq_front`

## Requirements
- R1: The maskable request is level sensitive and is acted on only in a cycle where `instr_end` is high. If the synchronized request is high and `if_flag` is high, `irq_take` rises one cycle later with `irq_type` equal to `INTR_TYPE` (default 8'h20) and `irq_is_nmi` low. While `instr_end` stays low, the request has no effect.
- R2: While `if_flag` is low, a high maskable request raises nothing at a boundary.
- R3: A low-to-high transition of the synchronized `pin_nmi` leaves a pending request. At the next boundary, `irq_take` rises with `irq_type` equal to `NMI_TYPE` (default 2) and `irq_is_nmi` high. If the pin stays high, no further request follows.
- R4: The non-maskable request is taken whatever the value of `if_flag`.
- R5: When both requests are present at a boundary, the non-maskable one is raised first. The maskable one can be raised at a later boundary.
- R6: `irq_take` holds with its type and flag until the cycle after `irq_ack` is seen high. Acknowledging a non-maskable request clears its pending state.
- R7: `core_rst` rises only after the synchronized reset has been seen high for `RST_MIN` (default 4) consecutive cycles, following a low. It falls one cycle after the synchronized reset is seen low. A pin pulse N cycles long (N ≥ `RST_MIN`) gives N−`RST_MIN`+1 cycles of `core_rst`. A shorter pulse gives none.
- R8: A qualified reset clears any pending non-maskable request and any raised `irq_take`. Nothing is raised while `core_rst` is high.
- R9: Every pin passes through `SYNC_STAGES` (default 2) flops. `test_sync` follows `pin_test` two clock edges after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset of the block itself |
| pin_intr | input | 1 | Raw maskable interrupt request, active high, asynchronous |
| pin_nmi | input | 1 | Raw non-maskable interrupt, rising edge, asynchronous |
| pin_reset | input | 1 | Raw reset pin, active high, asynchronous |
| pin_test | input | 1 | Raw test pin for the wait instruction, asynchronous |
| instr_end | input | 1 | High in the last cycle of each instruction |
| if_flag | input | 1 | Core interrupt-enable flag |
| irq_ack | input | 1 | Core accepts the raised request |
| irq_take | output | 1 | An interrupt must be entered |
| irq_type | output | TYPE_W | Type code of the raised request |
| irq_is_nmi | output | 1 | Raised request is the non-maskable one |
| core_rst | output | 1 | Qualified reset to the core |
| test_sync | output | 1 | Synchronized test level |

## Verification
The assertions assume that the core pulses `irq_ack` only while `irq_take` is high and never strobes `instr_end` in the cycle it acknowledges. The bench's boundary task keeps to this: it raises `instr_end` for exactly one cycle and acknowledges only after a request has appeared. Each pin is held stable for at least two clock edges, so that every change gets through the synchronizer. Reset pulses are timed in whole cycles so that the length of `core_rst` can be predicted exactly.

// File: rtl/cpu_irq_pkg.sv
// Shared parameters and types for the interrupt and reset front-end.
package cpu_irq_pkg;
    // Bit positions of the raw pins inside the synchronizer bundle.
    localparam int PIN_INTR  = 0;
    localparam int PIN_NMI   = 1;
    localparam int PIN_RESET = 2;
    localparam int PIN_TEST  = 3;
    localparam int PIN_COUNT = 4;

    // Source of the request currently raised to the core.
    typedef enum logic [0:0] {
        SRC_MASKABLE = 1'b0,
        SRC_NMI      = 1'b1
    } irq_src_e;
endpackage

// File: rtl/cpu_irq_sync.sv
// Multi-flop synchronizer bank.
// Each bit of async_in passes through STAGES flops clocked by clk.
// Assumes the inputs are independent levels. No bus coherence is implied.
module cpu_irq_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Capture the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= async_in;
            end
        end else begin : g_next
            // Shift through the later stages.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/cpu_irq_nmi_latch.sv
// Rising-edge detector and pending latch for the non-maskable request.
// Assumes nmi_s is already synchronized. clr is a one-cycle pulse when the
// core accepts the request. flush is the qualified core reset.
module cpu_irq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_s,
    input  logic clr,
    input  logic flush,
    output logic pend
);
    logic nmi_prev;
    logic edge_seen;

    assign edge_seen = nmi_s & ~nmi_prev;

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_prev <= 1'b0;
        else        nmi_prev <= nmi_s;
    end

    // Set on an edge, clear on acceptance or flush. An edge in the same cycle wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) pend <= 1'b0;
        else                 pend <= edge_seen | (pend & ~clr);
    end
endmodule

// File: rtl/cpu_irq_rst_qual.sv
// Reset length qualifier.
// Counts consecutive high samples of the synchronized reset. A count only
// starts once the reset has been seen low since the block's own reset.
// core_rst rises after RST_MIN samples and falls one cycle after a low sample.
module cpu_irq_rst_qual #(
    parameter int RST_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_s,
    output logic core_rst
);
    localparam int CNT_W = $clog2(RST_MIN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_MIN - 1);

    logic [CNT_W-1:0] high_cnt;
    logic             seen_low;

    // Count high samples and assert the qualified reset at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_cnt <= '0;
            seen_low <= 1'b0;
            core_rst <= 1'b0;
        end else if (!rst_s) begin
            high_cnt <= '0;
            seen_low <= 1'b1;
            core_rst <= 1'b0;
        end else if (seen_low && !core_rst) begin
            if (high_cnt == CNT_LAST) core_rst <= 1'b1;
            else                      high_cnt <= high_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cpu_irq_arb.sv
// Boundary arbiter.
// At an instruction boundary it raises one request: the pending non-maskable
// one first, otherwise the enabled maskable level. The request holds until
// acknowledged. Assumes ack is only pulsed while take is high.
module cpu_irq_arb
    import cpu_irq_pkg::*;
#(
    parameter int                TYPE_W    = 8,
    parameter logic [TYPE_W-1:0] INTR_TYPE = TYPE_W'(8'h20),
    parameter logic [TYPE_W-1:0] NMI_TYPE  = TYPE_W'(2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_end,
    input  logic              nmi_pend,
    input  logic              intr_s,
    input  logic              if_flag,
    input  logic              ack,
    input  logic              flush,
    output logic              take,
    output irq_src_e          src,
    output logic [TYPE_W-1:0] type_code,
    output logic              nmi_clr
);
    // Accepting a raised non-maskable request releases its pending latch.
    assign nmi_clr = take & ack & (src == SRC_NMI);

    // Raise, hold and drop the request toward the core.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            take      <= 1'b0;
            src       <= SRC_MASKABLE;
            type_code <= '0;
        end else if (take) begin
            if (ack) take <= 1'b0;
        end else if (instr_end) begin
            if (nmi_pend) begin
                take      <= 1'b1;
                src       <= SRC_NMI;
                type_code <= NMI_TYPE;
            end else if (intr_s && if_flag) begin
                take      <= 1'b1;
                src       <= SRC_MASKABLE;
                type_code <= INTR_TYPE;
            end
        end
    end
endmodule

// File: rtl/cpu_irq_front.sv
// Interrupt and reset front-end of a small CPU core.
// Synchronizes the raw control pins and qualifies the reset length. At each
// instruction boundary it decides which interrupt, if any, the core enters.
// Assumes the core holds instr_end for one cycle per instruction.
module cpu_irq_front
    import cpu_irq_pkg::*;
#(
    parameter int                TYPE_W      = 8,
    parameter logic [TYPE_W-1:0] INTR_TYPE   = TYPE_W'(8'h20),
    parameter logic [TYPE_W-1:0] NMI_TYPE    = TYPE_W'(2),
    parameter int                SYNC_STAGES = 2,
    parameter int                RST_MIN     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_intr,
    input  logic              pin_nmi,
    input  logic              pin_reset,
    input  logic              pin_test,
    input  logic              instr_end,
    input  logic              if_flag,
    input  logic              irq_ack,
    output logic              irq_take,
    output logic [TYPE_W-1:0] irq_type,
    output logic              irq_is_nmi,
    output logic              core_rst,
    output logic              test_sync
);
    logic [PIN_COUNT-1:0] raw_pins;
    logic [PIN_COUNT-1:0] sync_pins;
    logic                 nmi_pend;
    logic                 nmi_clr;
    irq_src_e             take_src;

    assign raw_pins[PIN_INTR]  = pin_intr;
    assign raw_pins[PIN_NMI]   = pin_nmi;
    assign raw_pins[PIN_RESET] = pin_reset;
    assign raw_pins[PIN_TEST]  = pin_test;

    cpu_irq_sync #(
        .WIDTH (PIN_COUNT),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(raw_pins),
        .sync_out(sync_pins)
    );

    cpu_irq_rst_qual #(
        .RST_MIN(RST_MIN)
    ) u_rst_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_s   (sync_pins[PIN_RESET]),
        .core_rst(core_rst)
    );

    cpu_irq_nmi_latch u_nmi (
        .clk  (clk),
        .rst_n(rst_n),
        .nmi_s(sync_pins[PIN_NMI]),
        .clr  (nmi_clr),
        .flush(core_rst),
        .pend (nmi_pend)
    );

    cpu_irq_arb #(
        .TYPE_W   (TYPE_W),
        .INTR_TYPE(INTR_TYPE),
        .NMI_TYPE (NMI_TYPE)
    ) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .instr_end(instr_end),
        .nmi_pend (nmi_pend),
        .intr_s   (sync_pins[PIN_INTR]),
        .if_flag  (if_flag),
        .ack      (irq_ack),
        .flush    (core_rst),
        .take     (irq_take),
        .src      (take_src),
        .type_code(irq_type),
        .nmi_clr  (nmi_clr)
    );

    assign irq_is_nmi = (take_src == SRC_NMI);
    assign test_sync  = sync_pins[PIN_TEST];
endmodule

// File: rtl/cpu_irq_front_chk.sv
// Protocol and timing checker for cpu_irq_front, attached by bind.
module cpu_irq_front_chk #(
    parameter int                TYPE_W   = 8,
    parameter logic [TYPE_W-1:0] NMI_TYPE = TYPE_W'(2),
    parameter int                RST_MIN  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_end,
    input logic              if_flag,
    input logic              irq_ack,
    input logic              pin_reset,
    input logic              irq_take,
    input logic [TYPE_W-1:0] irq_type,
    input logic              irq_is_nmi,
    input logic              core_rst
);
    localparam int RW = $clog2(RST_MIN + 1);
    localparam logic [RW-1:0] RMAX = RW'(RST_MIN);

    logic [RW-1:0] run_cnt;
    logic [RW-1:0] last_run;

    // Track the length of the current and of the last completed high run of the raw reset pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt  <= '0;
            last_run <= '0;
        end else if (pin_reset) begin
            if (run_cnt != RMAX) run_cnt <= run_cnt + 1'b1;
        end else begin
            if (run_cnt != '0) last_run <= run_cnt;
            run_cnt <= '0;
        end
    end

    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_take) |-> $past(instr_end)); // R1
    AST_MASK_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_take) && !irq_is_nmi) |-> $past(if_flag)); // R2
    AST_NMI_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && irq_is_nmi) |-> (irq_type == NMI_TYPE)); // R3
    AST_TAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && !irq_ack && !core_rst) |=> (irq_take && $stable(irq_type) && $stable(irq_is_nmi))); // R6
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && irq_ack) |=> !irq_take); // R6
    AST_RST_LONG_ENOUGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst) |-> (run_cnt == RMAX || last_run == RMAX)); // R7
    AST_NO_TAKE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> !irq_take); // R8
endmodule

bind cpu_irq_front cpu_irq_front_chk #(
    .TYPE_W  (TYPE_W),
    .NMI_TYPE(NMI_TYPE),
    .RST_MIN (RST_MIN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr_end (instr_end),
    .if_flag   (if_flag),
    .irq_ack   (irq_ack),
    .pin_reset (pin_reset),
    .irq_take  (irq_take),
    .irq_type  (irq_type),
    .irq_is_nmi(irq_is_nmi),
    .core_rst  (core_rst)
);

// File: tb/cpu_irq_front_tb.sv
// Scoreboard bench: the boundary driver queues the expected requests, and a monitor compares each raised one.
module cpu_irq_front_tb;
    localparam logic [7:0] T_INTR = 8'h20;
    localparam logic [7:0] T_NMI  = 8'h02;
    localparam int         RMIN   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_intr = 1'b0, pin_nmi = 1'b0, pin_reset = 1'b0, pin_test = 1'b0;
    logic       instr_end = 1'b0, if_flag = 1'b0, irq_ack = 1'b0;
    logic       irq_take, irq_is_nmi, core_rst, test_sync;
    logic [7:0] irq_type;

    int n_cmp = 0;
    int n_bad = 0;
    logic [8:0] exp_q[$];
    logic       take_seen = 1'b0;

    always #5 clk = ~clk;

    cpu_irq_front u_dut (
        .clk(clk), .rst_n(rst_n), .pin_intr(pin_intr), .pin_nmi(pin_nmi),
        .pin_reset(pin_reset), .pin_test(pin_test), .instr_end(instr_end),
        .if_flag(if_flag), .irq_ack(irq_ack), .irq_take(irq_take),
        .irq_type(irq_type), .irq_is_nmi(irq_is_nmi), .core_rst(core_rst),
        .test_sync(test_sync)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One instruction boundary. It queues the expected request, strobes, checks and acknowledges.
    task automatic boundary(input string req, input bit exp_take, input bit exp_nmi, input logic [7:0] exp_ty);
        if (exp_take) exp_q.push_back({exp_nmi, exp_ty});
        @(negedge clk) instr_end = 1'b1;
        @(negedge clk) instr_end = 1'b0;
        check(req, irq_take, exp_take);
        if (irq_take) begin
            cycles(1);
            check({req, " hold"}, irq_take, 1);
            irq_ack = 1'b1;
            @(negedge clk) irq_ack = 1'b0;
            check({req, " ack"}, irq_take, 0);
        end
    endtask

    // Drive a reset pulse of n cycles and count the cycles in which core_rst is high.
    task automatic rst_pulse(input int n, output int hi);
        hi = 0;
        pin_reset = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (core_rst) hi++;
        end
        pin_reset = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (core_rst) hi++;
        end
    endtask

    // Monitor: compare each newly raised request against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && irq_take && !take_seen) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R1/R3: unexpected request type %0h nmi %0b, expected none", irq_type, irq_is_nmi);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check("R5 order/type", {23'd0, irq_is_nmi, irq_type}, {23'd0, e});
            end
        end
        take_seen = irq_take;
    end

    initial begin
        int hi;
        fork
            begin
                cycles(3);
                rst_n = 1'b1;
                cycles(4);
                check("R8 reset take", irq_take, 0);
                check("R7 reset core_rst", core_rst, 0);
                check("R9 reset test", test_sync, 0);

                // R9: two-edge latency on the test pin.
                pin_test = 1'b1;
                cycles(1); check("R9 test after 1", test_sync, 0);
                cycles(1); check("R9 test after 2", test_sync, 1);
                pin_test = 1'b0;
                cycles(2); check("R9 test low", test_sync, 0);

                // R1: enabled maskable level taken at a boundary only.
                if_flag = 1'b1; pin_intr = 1'b1;
                cycles(6);
                check("R1 no boundary", irq_take, 0);
                boundary("R1 maskable", 1, 0, T_INTR);

                // R2: masked level ignored.
                if_flag = 1'b0;
                boundary("R2 masked", 0, 0, 8'h00);
                pin_intr = 1'b0;
                cycles(3);

                // R3: edge pending until a boundary, not repeated while held high.
                pin_nmi = 1'b1;
                cycles(8);
                check("R3 pending no boundary", irq_take, 0);
                if_flag = 1'b1;
                boundary("R3 nmi", 1, 1, T_NMI);
                boundary("R3 held level", 0, 0, 8'h00);
                pin_nmi = 1'b0; cycles(3);

                // R4: not masked.
                if_flag = 1'b0;
                pin_nmi = 1'b1; cycles(3); pin_nmi = 1'b0; cycles(3);
                boundary("R4 nmi masked flag", 1, 1, T_NMI);

                // R5: both at one boundary.
                if_flag = 1'b1; pin_intr = 1'b1;
                pin_nmi = 1'b1; cycles(3); pin_nmi = 1'b0; cycles(3);
                boundary("R5 nmi first", 1, 1, T_NMI);
                boundary("R5 maskable next", 1, 0, T_INTR);
                pin_intr = 1'b0; cycles(3);

                // R7: reset length qualification.
                rst_pulse(RMIN - 1, hi); check("R7 short pulse", hi, 0);
                rst_pulse(RMIN, hi);     check("R7 min pulse", hi, 1);
                rst_pulse(RMIN + 3, hi); check("R7 long pulse", hi, 4);

                // R8: qualified reset flushes a pending nmi.
                pin_nmi = 1'b1; cycles(3); pin_nmi = 1'b0; cycles(3);
                rst_pulse(RMIN + 1, hi); check("R8 reset seen", hi, 2);
                boundary("R8 flushed", 0, 0, 8'h00);

                cycles(3);
                check("R6 queue empty", exp_q.size(), 0);
            end
            begin
                cycles(200000);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule